// File: doc/BRIEF.md
# Oscillator Band Search Controller

This controller chooses one of a set of oscillator bands for a frequency synthesizer. Software programs a starting band and either uses it directly, or enables automatic selection and starts a search by writing the low byte of the integer divider. During a search the controller drives a band index and waits a fixed settling time. It then samples a 3-bit quantised reading of the loop tuning voltage. If the reading falls outside the narrow inner window, it moves one band up or down.

The search succeeds on the first band whose reading lies in the inner window. This leaves margin for the band to drift with temperature. The search fails when the next step would leave the band range or would return to a band already tried. Two separate flags report the result: one says the controller is idle (done) and one says the last search found a band (success). An activity flag is high while a search runs. When automatic selection is off, software can capture the tuning reading into a readback register on request.

Top module: `vco_band_search`

## Requirements
- R1: After reset, done=1, success=0, active=0 and code_rb=000.
- R2: While auto_en=0, band_sel equals start_band in the same cycle, whatever the search state.
- R3: A search starts only on an nlow_wr strobe with auto_en=1 and no search running. The strobe is ignored while a search runs and also when auto_en=0. A start band above 23 ends at once with done=1, success=0 and active=0, and no search runs.
- R4: While a search runs, active=1 and done=0. Each band is held for SETTLE (256) clocks before its reading is sampled. done rises SETTLE × (number of bands tried) clocks after the trigger edge.
- R5: Readings 010, 011, 100 and 101 accept the band. Readings 000 and 001 step to the next higher index. Readings 110 and 111 step to the next lower index.
- R6: On acceptance, done=1, success=1 and active=0, and band_sel reports the accepted band.
- R7: A step above 23 or below 0, or a step to a band already tried in the same search, ends the search with done=1, success=0 and active=0. band_sel then shows the last band tried.
- R8: With auto_en=0, the readback register code_rb takes tune_code on the clock after a strobe of adc_latch_wr with adc_en=1. It holds its value in every other case: when adc_en=0, when no strobe arrives, and when auto_en=1.
- R9: With auto_en=1 and no search running, band_sel keeps the last search result even if start_band changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_band | input | 5 | Programmed band: used directly in manual mode, first band tried in automatic mode |
| auto_en | input | 1 | 1 selects automatic band search |
| nlow_wr | input | 1 | One-cycle strobe: low byte of the integer divider was written |
| adc_en | input | 1 | Manual reading capture enable |
| adc_latch_wr | input | 1 | One-cycle strobe: a 1 was written to the capture bit |
| tune_code | input | 3 | Quantised tuning-voltage reading |
| band_sel | output | 5 | Band index driven to the oscillator bank |
| active | output | 1 | Search in progress |
| done | output | 1 | No search in progress |
| success | output | 1 | Last search found a band |
| code_rb | output | 3 | Captured tuning reading |

## Verification
A wrong settle count or a wrong reload shows first in the time from trigger to done. That time is checked to the exact clock against SETTLE times the number of bands tried, so a count that is off by one is caught when the search ends. A wrong step direction, a missed wrap or a lost record of tried bands shows at the end of the search: the final band_sel or the success flag is wrong, within a few settle periods. A stuck flag shows within half a settle period, because activity and done are sampled in the middle of every search.

// File: rtl/vco_band_search.sv
module vco_band_search #(
  parameter int NUM_BANDS = 24,
  parameter int BAND_W    = 5,
  parameter int CODE_W    = 3,
  parameter int SETTLE    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BAND_W-1:0] start_band,
  input  logic              auto_en,
  input  logic              nlow_wr,
  input  logic              adc_en,
  input  logic              adc_latch_wr,
  input  logic [CODE_W-1:0] tune_code,
  output logic [BAND_W-1:0] band_sel,
  output logic              active,
  output logic              done,
  output logic              success,
  output logic [CODE_W-1:0] code_rb
);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0]     CNT_LOAD = CNT_W'(SETTLE - 1);
  localparam logic [BAND_W-1:0]    LAST     = BAND_W'(NUM_BANDS - 1);
  localparam logic [NUM_BANDS-1:0] VIS_ONE  = NUM_BANDS'(1);
  localparam logic [CODE_W-1:0]    WIN_LO   = CODE_W'(2);
  localparam logic [CODE_W-1:0]    WIN_HI   = CODE_W'(5);

  logic [BAND_W-1:0]    band_q;
  logic [CNT_W-1:0]     cnt;
  logic [NUM_BANDS-1:0] visited;

  logic [NUM_BANDS-1:0] visited_nx;
  logic [BAND_W-1:0]    up_idx, dn_idx;
  logic                 in_win, go_up, vis_up, vis_dn, manual_cap;

  assign band_sel   = auto_en ? band_q : start_band;
  assign in_win     = (tune_code >= WIN_LO) && (tune_code <= WIN_HI);
  assign go_up      = tune_code < WIN_LO;
  assign up_idx     = band_q + 1'b1;
  assign dn_idx     = band_q - 1'b1;
  assign visited_nx = visited | (VIS_ONE << band_q);
  assign vis_up     = |(visited_nx & (VIS_ONE << up_idx));
  assign vis_dn     = |(visited_nx & (VIS_ONE << dn_idx));
  assign manual_cap = !auto_en && adc_en && adc_latch_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      band_q  <= '0;
      cnt     <= '0;
      visited <= '0;
      active  <= 1'b0;
      done    <= 1'b1;
      success <= 1'b0;
      code_rb <= '0;
    end else begin
      if (manual_cap)
        code_rb <= tune_code;
      if (!active) begin
        if (nlow_wr && auto_en) begin
          success <= 1'b0;
          if (start_band <= LAST) begin
            active  <= 1'b1;
            done    <= 1'b0;
            band_q  <= start_band;
            visited <= '0;
            cnt     <= CNT_LOAD;
          end else begin
            done    <= 1'b1;
          end
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        visited <= visited_nx;
        if (in_win) begin
          active  <= 1'b0;
          done    <= 1'b1;
          success <= 1'b1;
        end else if (go_up ? (band_q == LAST || vis_up)
                           : (band_q == '0 || vis_dn)) begin
          active  <= 1'b0;
          done    <= 1'b1;
          success <= 1'b0;
        end else begin
          band_q <= go_up ? up_idx : dn_idx;
          cnt    <= CNT_LOAD;
        end
      end
    end
  end

  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rst_n |=> (done && !success && !active && code_rb == '0)); // R1

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (nlow_wr && auto_en && !active && start_band <= LAST)
      |=> (active && !done && band_q == $past(start_band))); // R3

  AST_IDLE_XOR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    active != done); // R4

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && band_q != $past(band_q))
      |-> (band_q == $past(band_q) + 1'b1 || band_q + 1'b1 == $past(band_q))); // R5

  AST_SUCCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> (done && !active)); // R6

  AST_BAND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> band_q <= LAST); // R7

  AST_READBACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_cap |=> $stable(code_rb)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(nlow_wr && auto_en)) |=> $stable(band_q)); // R9
endmodule

// File: tb/vco_band_search_test.sv
module vco_band_search_test;
  localparam int SETTLE = 256;
  localparam int NV = 9;
  // start, lo, hi, expected band, expected success, bands tried
  localparam int VEC [NV][6] = '{
    '{10, 10, 10, 10, 1, 1},
    '{ 5,  8,  9,  8, 1, 4},
    '{20, 12, 15, 15, 1, 6},
    '{23, 24, 30, 23, 0, 1},
    '{ 0, -5, -1,  0, 0, 1},
    '{ 7,  8,  7,  8, 0, 2},
    '{ 0, 23, 23, 23, 1, 24},
    '{23,  0,  0,  0, 1, 24},
    '{12,  3, 20, 12, 1, 1}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic [4:0] start_band = 0;
  logic auto_en = 0, nlow_wr = 0, adc_en = 0, adc_latch_wr = 0;
  logic [2:0] tune_code;
  logic [4:0] band_sel;
  logic active, done, success;
  logic [2:0] code_rb;

  int lo = 0, hi = 0;
  logic ovr_en = 0;
  logic [2:0] ovr_code = 0;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  vco_band_search uut (
    .clk(clk), .rst_n(rst_n), .start_band(start_band), .auto_en(auto_en),
    .nlow_wr(nlow_wr), .adc_en(adc_en), .adc_latch_wr(adc_latch_wr),
    .tune_code(tune_code), .band_sel(band_sel), .active(active),
    .done(done), .success(success), .code_rb(code_rb));

  // Reading model: low codes below the window, high codes above, inner codes inside
  always_comb begin
    int b;
    b = int'(band_sel);
    if (ovr_en) tune_code = ovr_code;
    else if (b < lo) tune_code = b[0] ? 3'b000 : 3'b001;
    else if (b > hi) tune_code = b[0] ? 3'b110 : 3'b111;
    else tune_code = 3'(2 + (b % 4));
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk); nlow_wr = 1;
    @(negedge clk); nlow_wr = 0;
  endtask

  task automatic wait_done(input int retrig_at, output int cyc,
                           output int mid_act, output int mid_done);
    cyc = 0; mid_act = -1; mid_done = -1;
    while (cyc < 8000) begin
      @(negedge clk);
      cyc++;
      nlow_wr = (cyc == retrig_at);
      if (cyc == SETTLE / 2) begin mid_act = int'(active); mid_done = int'(done); end
      if (done) break;
    end
    nlow_wr = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cyc, ma, md;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done", int'(done), 1);
    chk("R1 success", int'(success), 0);
    chk("R1 active", int'(active), 0);
    chk("R1 code_rb", int'(code_rb), 0);

    // R2 manual band and R3 trigger ignored when auto is off
    start_band = 17;
    #1 chk("R2 manual band", int'(band_sel), 17);
    pulse_trig();
    @(negedge clk);
    chk("R3 no start when auto off", int'(active), 0);

    // Vector walk: R4 R5 R6 R7
    auto_en = 1;
    for (int i = 0; i < NV; i++) begin
      start_band = 5'(VEC[i][0]); lo = VEC[i][1]; hi = VEC[i][2];
      pulse_trig();
      wait_done(-1, cyc, ma, md);
      chk($sformatf("R4 v%0d cycles", i), cyc, SETTLE * VEC[i][5]);
      chk($sformatf("R4 v%0d mid active", i), ma, 1);
      chk($sformatf("R4 v%0d mid done", i), md, 0);
      chk($sformatf("R5 v%0d band", i), int'(band_sel), VEC[i][3]);
      chk($sformatf("%s v%0d success", VEC[i][4] ? "R6" : "R7", i), int'(success), VEC[i][4]);
      chk($sformatf("R6 v%0d idle", i), int'(active), 0);
    end

    // R9 result holds after start_band changes
    start_band = 2;
    @(negedge clk);
    chk("R9 result hold", int'(band_sel), 12);

    // R3 retrigger during search ignored
    start_band = 5; lo = 8; hi = 9;
    pulse_trig();
    start_band = 0;
    wait_done(300, cyc, ma, md);
    chk("R3 retrigger cycles", cyc, SETTLE * 4);
    chk("R3 retrigger band", int'(band_sel), 8);

    // R3 out-of-range start band
    start_band = 24;
    pulse_trig();
    chk("R3 bad start done", int'(done), 1);
    chk("R3 bad start success", int'(success), 0);
    chk("R3 bad start active", int'(active), 0);

    // R8 manual readback capture
    ovr_en = 1; ovr_code = 3'd5; auto_en = 0; adc_en = 0;
    @(negedge clk); adc_latch_wr = 1; @(negedge clk); adc_latch_wr = 0;
    chk("R8 no capture without enable", int'(code_rb), 0);
    adc_en = 1;
    @(negedge clk); adc_latch_wr = 1; @(negedge clk); adc_latch_wr = 0;
    chk("R8 capture", int'(code_rb), 5);
    ovr_code = 3'd6;
    repeat (2) @(negedge clk);
    chk("R8 hold without strobe", int'(code_rb), 5);
    auto_en = 1; ovr_code = 3'd2;
    @(negedge clk); adc_latch_wr = 1; @(negedge clk); adc_latch_wr = 0;
    chk("R8 no capture in auto mode", int'(code_rb), 5);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule